// File: doc/BRIEF.md
# Two-Tone Electrophoretic Panel Scan Sequencer

This block drives the row and column timing of a two-tone active-matrix electrophoretic panel. Each pixel is one switching transistor and one storage capacitor. A start pulse launches an update. The update first runs a number of erase passes that alternate an all-white and an all-black frame. It then runs a number of passes that write the stored picture. In every pass the rows are written in order. For each row the sequencer loads a row buffer, drives it onto the column outputs and waits a guard time. It then pulses that row's gate line, waits a second guard time after the gate falls, and moves to the next row. After the last row of each pass it holds the pattern for a fixed interval.

All timing is counted in slow ticks. A prescaler divides the master clock to make these ticks, and it is realigned at the start of every wait, so a wait of N ticks always lasts N times the prescale ratio in master cycles. Picture pixels come from an external frame store through a synchronous read port with a latency of one cycle, addressed by row and column. Pixels are one bit each: 1 selects the black column drive level and 0 selects white. Shifting to the panel's analog rail levels happens outside the block.

Top module: `epd_scan_seq`

## Requirements
- R1: A start pulse seen while idle makes busy high on the next cycle and begins the update at row 0 of pass 0.
- R2: A gate line rises exactly D2G_TICKS×PRESCALE cycles after the columns are updated for its row. Loading a row takes 1 cycle in an erase pass and COLS+2 cycles in a picture pass, counted from the cycle the load begins.
- R3: After a gate falls, the column outputs do not change for at least G2D_TICKS×PRESCALE cycles.
- R4: Every gate pulse lasts exactly GATE_TICKS×PRESCALE cycles.
- R5: Rows are scanned from row 0 upward, one at a time. Bit r of the gate bus drives row r, and at most one gate bit is ever high.
- R6: The first REFRESH_PASSES passes drive every column to the same level: white (0) in even-numbered passes starting from pass 0, and black (1) in odd-numbered passes.
- R7: The next IMAGE_PASSES passes drive column bit c with the stored pixel at (row, column c), which the frame store returns one cycle after it is addressed.
- R8: After the last row of a pass, the block waits G2D_TICKS plus HOLD_TICKS ticks before loading the next pass. After the final pass, done comes exactly (G2D_TICKS+HOLD_TICKS)×PRESCALE cycles after the last gate falls.
- R9: Done is a one-cycle pulse. Busy falls in the same cycle as done, and every update ends after exactly (REFRESH_PASSES+IMAGE_PASSES)×ROWS gate pulses.
- R10: A synchronous reset returns the block to idle. On the cycle after reset, all gates are low, busy is low and the columns are zero.
- R11: A start pulse that arrives while busy has no effect. The update in progress keeps its sequence, and only one done follows.
- R12: Frame-store reads are issued only while busy, and always for the row currently being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launch one update when idle |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle pulse at the end of the update |
| gate_o | output | ROWS | Row select lines, bit r is row r |
| col_o | output | COLS | Column levels, 1 black, 0 white |
| rd_en_o | output | 1 | Frame-store read request |
| rd_row_o | output | ROW_W | Frame-store row address |
| rd_col_o | output | COL_W | Frame-store column address |
| rd_pix_i | input | 1 | Pixel returned one cycle after the request |

## Verification
The assertions assume that the frame store answers every read exactly one cycle later. They also assume that reset is driven to a known level from the first clock edge, and that start is a single-cycle level change. The bench meets these assumptions with a registered frame-store model and by holding reset from time zero. It drives start and reset only on falling edges, as one-cycle pulses. It adds a start pulse partway through a busy update and a reset partway through a second update, and it fills the frame store with both random and directed patterns.

// File: rtl/epd_pkg.sv
package epd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_D2G,
        ST_GATE,
        ST_G2D,
        ST_HOLD
    } seq_st_e;
endpackage

// File: rtl/epd_tick_div.sv
module epd_tick_div #(
    parameter int PRESCALE = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == CW'(PRESCALE - 1));
        if (rst || restart_i || tick_o) cnt_d = '0;
        else                            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) cnt_q <= cnt_d;
endmodule

// File: rtl/epd_row_loader.sv
module epd_row_loader #(
    parameter int ROWS = 146,
    parameter int COLS = 240,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             fill_i,
    input  logic             fill_val_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             rd_en_o,
    output logic [ROW_W-1:0] rd_row_o,
    output logic [COL_W-1:0] rd_col_o,
    input  logic             rd_pix_i,
    output logic             ready_o,
    output logic [COLS-1:0]  line_o
);
    typedef struct packed {
        logic             busy;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic             cap_v;
        logic [COL_W-1:0] cap_c;
        logic [COLS-1:0]  line;
        logic             ready;
    } ld_s;

    ld_s ld_d, ld_q;

    always_comb begin
        ld_d       = ld_q;
        ld_d.ready = 1'b0;
        ld_d.cap_v = ld_q.busy;
        ld_d.cap_c = ld_q.col;
        if (ld_q.busy) begin
            if (ld_q.col == COL_W'(COLS - 1)) ld_d.busy = 1'b0;
            else                              ld_d.col  = ld_q.col + 1'b1;
        end
        if (ld_q.cap_v) begin
            ld_d.line[ld_q.cap_c] = rd_pix_i;
            if (ld_q.cap_c == COL_W'(COLS - 1)) ld_d.ready = 1'b1;
        end
        if (start_i) begin
            if (fill_i) begin
                ld_d.line  = {COLS{fill_val_i}};
                ld_d.ready = 1'b1;
            end else begin
                ld_d.busy = 1'b1;
                ld_d.col  = '0;
                ld_d.row  = row_i;
            end
        end
        if (rst) ld_d = '0;
    end

    always_ff @(posedge clk) ld_q <= ld_d;

    assign rd_en_o  = ld_q.busy;
    assign rd_row_o = ld_q.row;
    assign rd_col_o = ld_q.col;
    assign ready_o  = ld_q.ready;
    assign line_o   = ld_q.line;
endmodule

// File: rtl/epd_scan_seq.sv
module epd_scan_seq #(
    parameter int PRESCALE       = 400,
    parameter int ROWS           = 146,
    parameter int COLS           = 240,
    parameter int D2G_TICKS      = 10,
    parameter int G2D_TICKS      = 10,
    parameter int GATE_TICKS     = 1,
    parameter int HOLD_TICKS     = 15,
    parameter int REFRESH_PASSES = 15,
    parameter int IMAGE_PASSES   = 15,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [ROWS-1:0]  gate_o,
    output logic [COLS-1:0]  col_o,
    output logic             rd_en_o,
    output logic [ROW_W-1:0] rd_row_o,
    output logic [COL_W-1:0] rd_col_o,
    input  logic             rd_pix_i
);
    import epd_pkg::*;

    localparam int PASSES = REFRESH_PASSES + IMAGE_PASSES;
    localparam int PASS_W = $clog2(PASSES + 1);
    localparam int MAX_A  = (D2G_TICKS > G2D_TICKS) ? D2G_TICKS : G2D_TICKS;
    localparam int MAX_B  = (GATE_TICKS > HOLD_TICKS) ? GATE_TICKS : HOLD_TICKS;
    localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW     = $clog2(MAX_T + 1);

    typedef struct packed {
        seq_st_e           st;
        logic [ROW_W-1:0]  row;
        logic [PASS_W-1:0] pass;
        logic [TW-1:0]     tcnt;
        logic [COLS-1:0]   col;
        logic              gate;
        logic              done;
    } seq_s;

    seq_s rs_d, rs_q;
    logic tick, restart, ld_start, ld_ready;
    logic [COLS-1:0] ld_line;

    epd_tick_div #(.PRESCALE(PRESCALE)) u_div (
        .clk(clk), .rst(rst), .restart_i(restart), .tick_o(tick)
    );

    epd_row_loader #(.ROWS(ROWS), .COLS(COLS)) u_ld (
        .clk(clk), .rst(rst), .start_i(ld_start),
        .fill_i(rs_d.pass < PASS_W'(REFRESH_PASSES)),
        .fill_val_i(rs_d.pass[0]), .row_i(rs_d.row),
        .rd_en_o(rd_en_o), .rd_row_o(rd_row_o), .rd_col_o(rd_col_o),
        .rd_pix_i(rd_pix_i), .ready_o(ld_ready), .line_o(ld_line)
    );

    always_comb begin
        rs_d      = rs_q;
        rs_d.done = 1'b0;
        restart   = 1'b0;
        ld_start  = 1'b0;
        unique case (rs_q.st)
            ST_IDLE: if (start_i) begin
                rs_d.st   = ST_LOAD;
                rs_d.row  = '0;
                rs_d.pass = '0;
                ld_start  = 1'b1;
            end
            ST_LOAD: if (ld_ready) begin
                rs_d.col  = ld_line;
                rs_d.st   = ST_D2G;
                rs_d.tcnt = '0;
                restart   = 1'b1;
            end
            ST_D2G: if (tick) begin
                if (rs_q.tcnt == TW'(D2G_TICKS - 1)) begin
                    rs_d.st   = ST_GATE;
                    rs_d.gate = 1'b1;
                    rs_d.tcnt = '0;
                    restart   = 1'b1;
                end else rs_d.tcnt = rs_q.tcnt + 1'b1;
            end
            ST_GATE: if (tick) begin
                if (rs_q.tcnt == TW'(GATE_TICKS - 1)) begin
                    rs_d.st   = ST_G2D;
                    rs_d.gate = 1'b0;
                    rs_d.tcnt = '0;
                    restart   = 1'b1;
                end else rs_d.tcnt = rs_q.tcnt + 1'b1;
            end
            ST_G2D: if (tick) begin
                if (rs_q.tcnt == TW'(G2D_TICKS - 1)) begin
                    rs_d.tcnt = '0;
                    if (rs_q.row == ROW_W'(ROWS - 1)) begin
                        rs_d.st = ST_HOLD;
                        restart = 1'b1;
                    end else begin
                        rs_d.row = rs_q.row + 1'b1;
                        rs_d.st  = ST_LOAD;
                        ld_start = 1'b1;
                    end
                end else rs_d.tcnt = rs_q.tcnt + 1'b1;
            end
            ST_HOLD: if (tick) begin
                if (rs_q.tcnt == TW'(HOLD_TICKS - 1)) begin
                    rs_d.tcnt = '0;
                    if (rs_q.pass == PASS_W'(PASSES - 1)) begin
                        rs_d.st   = ST_IDLE;
                        rs_d.done = 1'b1;
                    end else begin
                        rs_d.pass = rs_q.pass + 1'b1;
                        rs_d.row  = '0;
                        rs_d.st   = ST_LOAD;
                        ld_start  = 1'b1;
                    end
                end else rs_d.tcnt = rs_q.tcnt + 1'b1;
            end
            default: rs_d.st = ST_IDLE;
        endcase
        if (rst) begin
            rs_d     = '0;
            restart  = 1'b1;
            ld_start = 1'b0;
        end
    end

    always_ff @(posedge clk) rs_q <= rs_d;

    assign busy_o = (rs_q.st != ST_IDLE);
    assign done_o = rs_q.done;
    assign col_o  = rs_q.col;
    assign gate_o = rs_q.gate ? (ROWS'(1) << rs_q.row) : '0;
endmodule

// File: rtl/epd_scan_seq_chk.sv
module epd_scan_seq_chk #(
    parameter int ROWS = 146,
    parameter int COLS = 240
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [ROWS-1:0] gate_o,
    input logic [COLS-1:0] col_o,
    input logic            rd_en_o
);
    a_r5_one_gate: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_o));

    a_r2_cols_still_under_gate: assert property (@(posedge clk) disable iff (rst)
        (|gate_o) |-> $stable(col_o));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && gate_o == '0));

    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy_o && gate_o == '0 && !done_o));

    a_r12_reads_busy: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |-> busy_o);

    a_r1_start_begins: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o);

    a_r5_idle_gates_low: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> gate_o == '0);
endmodule

bind epd_scan_seq epd_scan_seq_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .gate_o(gate_o), .col_o(col_o), .rd_en_o(rd_en_o)
);

// File: tb/sim_epd_scan_seq.sv
module sim_epd_scan_seq;
    localparam int P   = 4;
    localparam int NR  = 4;
    localparam int NC  = 8;
    localparam int D2G = 3;
    localparam int G2D = 2;
    localparam int GW  = 2;
    localparam int HLD = 5;
    localparam int RP  = 3;
    localparam int IP  = 2;
    localparam int RW  = $clog2(NR);
    localparam int CW  = $clog2(NC);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, rd_en, rd_pix;
    logic [NR-1:0] gate;
    logic [NC-1:0] col;
    logic [RW-1:0] rd_row;
    logic [CW-1:0] rd_col;
    logic [NC-1:0] mem [NR];

    int checks = 0, fails = 0, cyc = 0, dones = 0;
    int t_ref = 0, t_rise = 0, t_fall = 0, exp_row = 0, exp_pass = 0, gates_run = 0;
    bit hold_pend = 0, prev_busy = 0;
    logic [NR-1:0] prev_gate = '0;
    logic [NC-1:0] prev_col = '0;

    always #10 clk = ~clk;

    epd_scan_seq #(
        .PRESCALE(P), .ROWS(NR), .COLS(NC), .D2G_TICKS(D2G), .G2D_TICKS(G2D),
        .GATE_TICKS(GW), .HOLD_TICKS(HLD), .REFRESH_PASSES(RP), .IMAGE_PASSES(IP)
    ) u0 (
        .clk(clk), .rst(rst), .start_i(start), .busy_o(busy), .done_o(done),
        .gate_o(gate), .col_o(col), .rd_en_o(rd_en), .rd_row_o(rd_row),
        .rd_col_o(rd_col), .rd_pix_i(rd_pix)
    );

    always @(posedge clk) rd_pix <= mem[rd_row][rd_col];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] exp_cols(input int pass, input int row);
        if (pass < RP) return {NC{pass[0]}};
        return mem[row];
    endfunction

    function automatic int load_len(input int pass);
        return (pass < RP) ? 1 : NC + 2;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
        if (!rst) begin
            if (busy && !prev_busy) begin
                t_ref = cyc; exp_row = 0; exp_pass = 0; gates_run = 0; hold_pend = 0;
            end
            if (rd_en) chk(busy && rd_row == RW'(exp_row), "R12 read row", rd_row, exp_row);
            if (col != prev_col && gates_run > 0)
                chk(cyc - t_fall >= (hold_pend ? G2D + HLD : G2D) * P, "R3 column guard",
                    cyc - t_fall, (hold_pend ? G2D + HLD : G2D) * P);
            if (gate != '0 && prev_gate == '0) begin
                chk(gate == NR'(1) << exp_row, "R5 row order", gate, NR'(1) << exp_row);
                chk(cyc - t_ref == load_len(exp_pass) + D2G * P, "R2 data to gate",
                    cyc - t_ref, load_len(exp_pass) + D2G * P);
                chk(col == exp_cols(exp_pass, exp_row),
                    exp_pass < RP ? "R6 erase level" : "R7 picture row",
                    col, exp_cols(exp_pass, exp_row));
                t_rise = cyc;
            end
            if (gate == '0 && prev_gate != '0) begin
                chk(cyc - t_rise == GW * P, "R4 gate width", cyc - t_rise, GW * P);
                t_fall = cyc;
                gates_run++;
                if (exp_row == NR - 1) begin
                    exp_row = 0; exp_pass++; hold_pend = 1;
                    t_ref = cyc + (G2D + HLD) * P;
                end else begin
                    exp_row++; hold_pend = 0;
                    t_ref = cyc + G2D * P;
                end
            end
            if (done) begin
                dones++;
                chk(gates_run == (RP + IP) * NR && !busy, "R9 gate count at done",
                    gates_run, (RP + IP) * NR);
                chk(cyc - t_fall == (G2D + HLD) * P, "R8 final hold",
                    cyc - t_fall, (G2D + HLD) * P);
            end
        end
        prev_busy = busy && !rst;
        prev_gate = gate;
        prev_col  = col;
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run_full(input bit poke);
        int d0;
        d0 = dones;
        pulse_start();
        chk(busy, "R1 busy after start", busy, 1);
        if (poke) begin
            repeat (250) @(negedge clk);
            pulse_start();
        end
        while (dones == d0) @(negedge clk);
        repeat (60) @(negedge clk);
        chk(dones == d0 + 1 && !busy, "R11 single done", dones - d0, 1);
    endtask

    initial begin
        void'($urandom(32'd7319));
        for (int r = 0; r < NR; r++) mem[r] = NC'($urandom);
        repeat (3) @(negedge clk);
        chk(gate == '0 && !busy && col == '0, "R10 reset state", {gate, col}, 0);
        rst = 1'b0;
        run_full(1'b1);
        mem[0] = '1; mem[1] = '0; mem[2] = 8'hA5; mem[3] = 8'h5A;
        run_full(1'b0);
        pulse_start();
        repeat (300) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(gate == '0 && !busy && col == '0, "R10 mid-run reset", {gate, col}, 0);
        rst = 1'b0;
        for (int r = 0; r < NR; r++) mem[r] = NC'($urandom);
        run_full(1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule